// File: doc/BRIEF.md
# Toggle-Encoded Serial Transmitter

This block sends 4-bit words over a single wire using a self-clocking, length-coded line format. Every bit begins with a forced change of level on the serial output. The value of the bit is carried by how long the line then holds that level: two clock cycles for a one and four for a zero. The bit lengths are parameters.

Words enter in parallel. The block raises a one-cycle fetch strobe, and the word on `din` is captured on the clock edge that ends that cycle. The bits then go out most significant first, from a left-shifting register. A countdown counter times each bit. A Mealy controller reads the counter's terminal count and the bit position, and it chooses either to shift to the next bit or to fetch the next word. The fetch replaces the shift at the end of a word's final bit, so words follow each other with no idle cycle.

Top module: `tgl_ser_tx`

## Requirements
- R1: While `rst` is sampled high, `ser_o` goes low. In the first cycle after `rst` drops, `fetch_o` is high and `ser_o` is still low.
- R2: `fetch_o` is high for exactly one cycle per word. That cycle is the first cycle after reset, or the final cycle of the previous word's least significant bit. In every other cycle `fetch_o` is low.
- R3: `ser_o` changes level on the clock edge that starts each bit. It holds that level for the rest of the bit.
- R4: A bit of value 0 lasts 4 clock cycles between level changes.
- R5: A bit of value 1 lasts 2 clock cycles between level changes.
- R6: The word captured while `fetch_o` is high is sent most significant bit (`din[3]`) first and `din[0]` last.
- R7: The first bit of a word starts on the edge that ends the `fetch_o` cycle, with no idle cycle between words.
- R8: A synchronous reset in the middle of a word abandons that word and returns the block to the state of R1.
- R9: `din` is ignored in every cycle in which `fetch_o` is low. Changing it then does not alter the bit lengths of the word in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 4 | Parallel word, sampled at the end of a `fetch_o` cycle |
| fetch_o | output | 1 | Word request strobe |
| ser_o | output | 1 | Length-coded serial line |

## Verification
Every bit starts with a level change, so a counter preset to the wrong length shows up at the port within that same bit. The interval to the next edge comes out as the wrong number of cycles. A stuck or mis-stepping bit index appears within one word, as a fetch strobe that comes early, late or not at all. A shift in the wrong direction alters the sequence of edge intervals from the second bit of a word onward. The bench therefore times every edge interval and checks the strobe in every cycle. It drives directed and random nibbles, and it toggles `din` between fetches.

// File: rtl/tgl_ser_tx.sv
module tgl_ser_tx #(
  parameter int W        = 4,
  parameter int ZERO_LEN = 4,
  parameter int ONE_LEN  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic         fetch_o,
  output logic         ser_o
);
  localparam int MAXL = (ZERO_LEN > ONE_LEN) ? ZERO_LEN : ONE_LEN;
  localparam int CW   = (MAXL > 1) ? $clog2(MAXL) : 1;
  localparam int BW   = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic          run;
  logic          tc, last, adv, nxt_msb;
  logic [CW-1:0] preset;

  assign tc      = (cnt == '0);
  assign last    = (bidx == BW'(W-1));
  assign fetch_o = !run || (tc && last);
  assign adv     = run && tc && !last;
  assign nxt_msb = fetch_o ? din[W-1] : sh[W-2];
  assign preset  = nxt_msb ? CW'(ONE_LEN-1) : CW'(ZERO_LEN-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      ser_o <= 1'b0;
      sh    <= '0;
      cnt   <= '0;
      bidx  <= '0;
    end else begin
      if (fetch_o) begin
        sh   <= din;
        bidx <= '0;
        run  <= 1'b1;
      end else if (adv) begin
        sh   <= {sh[W-2:0], 1'b0};
        bidx <= bidx + 1'b1;
      end
      if (fetch_o || adv) begin
        ser_o <= ~ser_o;
        cnt   <= preset;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

module tgl_ser_tx_chk #(
  parameter int W        = 4,
  parameter int ZERO_LEN = 4,
  parameter int ONE_LEN  = 2,
  parameter int CW       = 2,
  parameter int BW       = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_o,
  input logic          ser_o,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  sh
);
  AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (fetch_o && !ser_o && !run)); // R1
  AST_FETCH_SINGLE:      assert property (@(posedge clk) disable iff (rst) (fetch_o && run) |=> !fetch_o); // R2
  AST_TOGGLE_AT_START:   assert property (@(posedge clk) disable iff (rst) (fetch_o || (run && cnt == '0)) |=> (ser_o != $past(ser_o))); // R3
  AST_HOLD_IN_BIT:       assert property (@(posedge clk) disable iff (rst) (run && cnt != '0 && !fetch_o) |=> $stable(ser_o)); // R3
  AST_ZERO_LENGTH:       assert property (@(posedge clk) disable iff (rst) (run && !$stable(ser_o) && !sh[W-1]) |-> (cnt == CW'(ZERO_LEN-1))); // R4
  AST_ONE_LENGTH:        assert property (@(posedge clk) disable iff (rst) (run && !$stable(ser_o) && sh[W-1]) |-> (cnt == CW'(ONE_LEN-1))); // R5
endmodule

bind tgl_ser_tx tgl_ser_tx_chk #(.W(W), .ZERO_LEN(ZERO_LEN), .ONE_LEN(ONE_LEN), .CW(CW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .fetch_o(fetch_o), .ser_o(ser_o), .run(run), .cnt(cnt), .sh(sh)
);

// File: tb/tgl_ser_tx_tb.sv
module tgl_ser_tx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] din = 4'h0;
  logic       fetch_o, ser_o;
  logic       prev = 1'b0;
  int         checks = 0;
  int         fails  = 0;

  always #2.5 clk = ~clk;

  tgl_ser_tx u_dut (.clk(clk), .rst(rst), .din(din), .fetch_o(fetch_o), .ser_o(ser_o));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    chk(ser_o == 1'b0, "R1 line low in reset", ser_o, 0);
    rst = 1'b0;
    chk(fetch_o == 1'b1, "R1 fetch after reset", fetch_o, 1);
    chk(ser_o == 1'b0, "R1 line low after reset", ser_o, 0);
    prev = 1'b0;
  endtask

  task automatic send_word(input logic [3:0] w, input bit scram);
    chk(fetch_o == 1'b1, "R2 fetch at word start", fetch_o, 1);
    din = w;
    for (int i = 3; i >= 0; i--) begin
      int len = w[i] ? 2 : 4;
      int held = 1;
      bit fetch_ok = 1'b1;
      step();
      if (i == 3) chk(ser_o !== prev, "R7 toggle right after fetch", ser_o, !prev);
      else        chk(ser_o !== prev, "R3 toggle at bit start", ser_o, !prev);
      prev = ser_o;
      if (scram) din = 4'($urandom);
      for (int c = 1; c < len; c++) begin
        if (fetch_o) fetch_ok = 1'b0;
        step();
        if (ser_o === prev) held++;
      end
      if (ser_o === prev) begin
        if (w[i]) chk(1'b1, "R5", 0, 0);
        else      chk(1'b1, "R4", 0, 0);
      end
      if (scram)     chk(held == len, "R9 din change ignored, bit length", held, len);
      else if (w[i]) chk(held == len, "R5/R6 one bit length", held, len);
      else           chk(held == len, "R4/R6 zero bit length", held, len);
      chk(fetch_ok && (fetch_o == (i == 0)), "R2 fetch only at word end", fetch_o, (i == 0));
    end
  endtask

  task automatic reset_mid_word();
    chk(fetch_o == 1'b1, "R2 fetch before aborted word", fetch_o, 1);
    din = 4'h0;
    repeat (3) step();
    rst = 1'b1;
    step();
    step();
    chk(ser_o == 1'b0, "R8 line low after mid-word reset", ser_o, 0);
    rst = 1'b0;
    chk(fetch_o == 1'b1, "R8 fetch after mid-word reset", fetch_o, 1);
    prev = 1'b0;
  endtask

  initial begin
    do_reset();
    send_word(4'h0, 1'b0);
    send_word(4'hF, 1'b0);
    send_word(4'hA, 1'b0);
    send_word(4'h5, 1'b0);
    send_word(4'h8, 1'b0);
    send_word(4'h1, 1'b0);
    for (int k = 0; k < 8; k++) send_word(4'($urandom), 1'b0);
    for (int k = 0; k < 6; k++) send_word(4'($urandom), 1'b1);
    reset_mid_word();
    send_word(4'h9, 1'b0);
    send_word(4'h6, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule